// File: doc/BRIEF.md
# Capture/Compare Interval Timer

This block is a 16-bit up-counter that measures the time between edges on an external timer pin. Once software enables it, the counter holds its start value. It begins counting only when the first qualifying edge arrives on the pin. That arming edge raises no interrupt. From then on the counter advances once per prescaled clock tick. The prescaler divides the system clock by a power of two.

A later qualifying edge does three things: it latches the running count into a read-only capture register, sets a capture flag and pulses the interrupt. If no edge arrives, the counter climbs to the programmed compare value. It then pulses the interrupt and clears the capture flag. In both cases the counter restarts from one and keeps running. Software computes elapsed time as (captured count − start count) × prescale divisor / system clock frequency. A two-bit field chooses which of the two events may interrupt.

Software reaches the block through a small word-wide register port:

| Address | Register | Access | Contents |
|---------|----------|--------|----------|
| 0 | control | read/write | bit 0 enable, bit 1 falling-edge select (0 = rising), bits 4:2 prescale exponent N, bits 6:5 interrupt source |
| 1 | count | read/write | running count |
| 2 | compare | read/write | compare value |
| 3 | status | read-only | bit 0 capture flag |
| 4 | capture | read-only | captured count |

Top module: `capcmp_timer`

## Requirements
- R1: After reset the count reads 0, the compare register reads FFFFh, control and status read 0, the capture value is 0 and the interrupt is low.
- R2: While enabled but not yet armed, the count holds its value. The first qualifying edge arms counting and raises no interrupt.
- R3: Control bit 1 selects the qualifying edge: 0 means rising and 1 means falling. An edge of the other direction neither arms the timer nor captures.
- R4: When armed, the count advances once every 2^N system clocks, where N is control bits 4:2. The prescaler restarts from zero at the arming edge.
- R5: A qualifying edge while armed copies the count into the capture register, reloads the count to 1, sets status bit 0, and raises the interrupt if bits 6:5 are not 10.
- R6: When a prescaled tick finds the count equal to the compare value, the count reloads to 1, status bit 0 clears, and the interrupt is raised if bits 6:5 are not 01.
- R7: Control bits 6:5 select the interrupt source: 00 and 11 allow both events, 01 allows captures only, and 10 allows compare reloads only. A masked event still updates count, flag and capture.
- R8: When a capture and a compare reload fall on the same cycle, the capture wins: the capture register takes the compare value and status bit 0 is set.
- R9: A count write is ignored while the timer is enabled and takes effect while it is disabled. Reading any register never disturbs counting.
- R10: The pin passes through a two-flop synchroniser. A pin change is acted on at the third rising clock edge after it is presented.
- R11: Each event produces an interrupt pulse exactly one clock wide.
- R12: Clearing the enable bit disarms the timer. A later re-enable waits for a new arming edge, and the count holds in the meantime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| tmr_in | input | 1 | Asynchronous timer pin |
| irq | output | 1 | Interrupt pulse |
| cap_value | output | 16 | Last captured count |

## Verification
Several properties are checked on every cycle:
- the arming edge stays silent;
- an idle timer's count does not move unless software writes it;
- every interrupt coincides with a count of one;
- a capture interrupt carries the count from the cycle before;
- a restricted interrupt source never lets the other event through.

Other behaviours can be shown only by scripted pin waveforms, compared cycle by cycle against a behavioural model:
- rejection of the wrong edge direction;
- the exact prescaled step rate;
- three-edge synchroniser latency;
- the capture-over-compare tie;
- re-arming after a disable.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rd_data,
  input  logic             tmr_in,
  output logic             irq,
  output logic [CNT_W-1:0] cap_value
);
  localparam int PDIV_W = (1 << PRE_W) - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              en, pol, flag, armed;
  logic [PRE_W-1:0]  psel;
  logic [1:0]        isel;
  logic [CNT_W-1:0]  cnt, cmp, cap_q;
  logic [PDIV_W-1:0] pcnt;
  logic [2:0]        sync;

  wire ctrl_wr  = wr_en && (addr == ADDR_W'(0));
  wire cnt_wr   = wr_en && (addr == ADDR_W'(1)) && !en;
  wire cmp_wr   = wr_en && (addr == ADDR_W'(2));
  wire edge_hit = en && (pol ? (sync[2] & ~sync[1]) : (~sync[2] & sync[1]));
  wire running  = en && armed;
  wire tick     = running && (&(pcnt | ({PDIV_W{1'b1}} << psel)));
  wire cap_ev   = running && edge_hit;
  wire cmp_ev   = tick && !cap_ev && (cnt == cmp);
  wire irq_ok   = cap_ev ? (isel != 2'b10) : (isel != 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync  <= '0;
      en    <= 1'b0;
      pol   <= 1'b0;
      psel  <= '0;
      isel  <= '0;
      cnt   <= '0;
      cmp   <= '1;
      cap_q <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
      pcnt  <= '0;
      irq   <= 1'b0;
    end else begin
      sync <= {sync[1:0], tmr_in};
      irq  <= (cap_ev || cmp_ev) && irq_ok;
      pcnt <= running ? pcnt + 1'b1 : '0;

      if (cap_ev) begin
        cap_q <= cnt;
        cnt   <= ONE;
        flag  <= 1'b1;
      end else if (tick) begin
        if (cnt == cmp) begin
          cnt  <= ONE;
          flag <= 1'b0;
        end else begin
          cnt <= cnt + ONE;
        end
      end else if (cnt_wr) begin
        cnt <= wdata;
      end

      if (ctrl_wr && (!wdata[0] || !en)) armed <= 1'b0;
      else if (!en)                      armed <= 1'b0;
      else if (edge_hit)                 armed <= 1'b1;

      if (ctrl_wr) {isel, psel, pol, en} <= wdata[PRE_W+3:0];
      if (cmp_wr)  cmp <= wdata;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rd_data = CNT_W'({isel, psel, pol, en});
      ADDR_W'(1): rd_data = cnt;
      ADDR_W'(2): rd_data = cmp;
      ADDR_W'(3): rd_data = CNT_W'(flag);
      ADDR_W'(4): rd_data = cap_q;
      default:    rd_data = '0;
    endcase
  end

  assign cap_value = cap_q;
endmodule

module capcmp_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              irq,
  input logic              armed,
  input logic              flag,
  input logic [1:0]        isel,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cap_q
);
  wire count_write = wr_en && (addr == ADDR_W'(1));

  p_first_edge_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> !irq);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !count_write) |=> $stable(cnt));

  p_reload_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == CNT_W'(1)));

  p_cap_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && flag) |-> (cap_q == $past(cnt)));

  p_cap_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(isel) == 2'b01) |-> flag);

  p_cmp_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(isel) == 2'b10) |-> !flag);
endmodule

bind capcmp_timer capcmp_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .irq(irq),
  .armed(armed), .flag(flag), .isel(isel), .cnt(cnt), .cap_q(cap_q)
);

// File: tb/capcmp_timer_tb_top.sv
module capcmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd1;
  logic [15:0] wdata = '0;
  logic        tmr_in = 1'b0;
  logic [15:0] rd_data, cap_value;
  logic        irq;

  int checks = 0, failures = 0, irq_seen = 0;

  capcmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .tmr_in(tmr_in), .irq(irq), .cap_value(cap_value)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  int m_en, m_pol, m_n, m_sel, m_cnt, m_cmp, m_cap, m_flag, m_irq, m_armed, m_pre;
  int s1, s2, s3;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_n = 0; m_sel = 0; m_cnt = 0; m_cmp = 'hFFFF;
      m_cap = 0; m_flag = 0; m_irq = 0; m_armed = 0; m_pre = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      bit hit, tk;
      hit = (m_en != 0) && (m_pol != 0 ? (s3 == 1 && s2 == 0) : (s3 == 0 && s2 == 1));
      tk  = (m_pre % (1 << m_n)) == (1 << m_n) - 1;
      m_irq = 0;
      if (m_en != 0 && m_armed != 0) begin
        if (hit) begin
          m_cap = m_cnt; m_cnt = 1; m_flag = 1; m_irq = (m_sel != 2);
        end else if (tk) begin
          if (m_cnt == m_cmp) begin
            m_cnt = 1; m_flag = 0; m_irq = (m_sel != 1);
          end else m_cnt = (m_cnt + 1) & 'hFFFF;
        end
        m_pre = (m_pre + 1) % 128;
      end else begin
        m_pre = 0;
        if (m_en != 0 && hit) m_armed = 1;
      end
      if (m_en == 0) m_armed = 0;
      if (wr_en) begin
        case (addr)
          3'd0: begin
            if (wdata[0] == 1'b0 || m_en == 0) m_armed = 0;
            m_en = wdata[0]; m_pol = wdata[1]; m_n = wdata[4:2]; m_sel = wdata[6:5];
          end
          3'd1: if (m_en == 0) m_cnt = wdata;
          3'd2: m_cmp = wdata;
          default: ;
        endcase
      end
      s3 = s2; s2 = s1; s1 = tmr_in;
    end
  end

  function automatic int m_rd(input int a);
    case (a)
      0: return m_en | (m_pol << 1) | (m_n << 2) | (m_sel << 5);
      1: return m_cnt;
      2: return m_cmp;
      3: return m_flag;
      4: return m_cap;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      if (irq) irq_seen++;
      chk(irq == m_irq[0], "R5 R6 R7 irq", irq, m_irq);
      chk(cap_value == m_cap, "R5 capture", cap_value, m_cap);
      chk(rd_data == m_rd(addr), "R2 R4 R6 R9 read", rd_data, m_rd(addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk); wr_en = 1'b0; addr = 3'd1;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 3'(a); #1; v = rd_data;
  endtask

  task automatic pin(input bit v);
    @(negedge clk); tmr_in = v;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk); #3;
      if (irq) break;
    end
    @(posedge clk); #3;
    chk(!irq, "R11 pulse width", irq, 0);
  endtask

  initial begin
    #1200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, a, b, s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1, v); chk(v == 0, "R1 count", v, 0);
    rd(2, v); chk(v == 'hFFFF, "R1 compare", v, 'hFFFF);
    rd(3, v); chk(v == 0, "R1 status", v, 0);
    chk(irq == 0 && cap_value == 0, "R1 irq/capture", cap_value, 0);

    // falling-edge capture, compare reload
    wr(1, 100); wr(2, 120); wr(0, 'h03);
    wr(1, 5); rd(1, v); chk(v == 100, "R9 write ignored while enabled", v, 100);
    pin(1); repeat (8) @(negedge clk);
    rd(1, v); chk(v == 100, "R3 wrong edge ignored", v, 100);
    pin(0); repeat (10) @(negedge clk);
    chk(irq_seen == 0, "R2 arming edge silent", irq_seen, 0);
    rd(1, v); chk(v > 100, "R2 counting after arm", v, 101);
    s = irq_seen;
    pin(1); repeat (3) @(negedge clk); pin(0);
    wait_irq();
    chk(irq_seen == s + 1, "R5 capture irq", irq_seen, s + 1);
    rd(3, v); chk(v == 1, "R5 flag set", v, 1);
    chk(cap_value > 100, "R5 captured count", cap_value, 101);
    wait_irq();
    chk(irq_seen == s + 2, "R6 compare irq", irq_seen, s + 2);
    rd(3, v); chk(v == 0, "R6 flag cleared", v, 0);

    // prescale by 8
    wr(0, 0); wr(1, 0); wr(2, 'hFFFF); wr(0, 'h0D);
    pin(1); repeat (20) @(negedge clk);
    rd(1, a); repeat (7) @(negedge clk); rd(1, b);
    chk(b == a + 1, "R4 divide by 8", b, a + 1);

    // interrupt source selection
    wr(0, 0); wr(1, 0); wr(2, 5); wr(0, 'h21);
    pin(0); pin(1);
    s = irq_seen;
    repeat (40) @(negedge clk);
    chk(irq_seen == s, "R7 compare masked", irq_seen, s);
    wr(2, 'hFFFF); wr(0, 'h41);
    pin(0); pin(1); repeat (8) @(negedge clk);
    chk(irq_seen == s, "R7 capture masked", irq_seen, s);
    rd(3, v); chk(v == 1, "R7 masked capture still flags", v, 1);

    // capture and compare on the same cycle
    wr(0, 0); wr(1, 0); wr(2, 40); wr(0, 'h01);
    pin(0); pin(1); pin(0);
    do @(negedge clk); while (m_cnt != 38);
    tmr_in = 1'b1;
    wait_irq();
    chk(cap_value == 40, "R8 R10 capture wins at compare", cap_value, 40);
    rd(3, v); chk(v == 1, "R8 flag set", v, 1);

    // disable disarms
    wr(0, 0); wr(0, 1);
    rd(1, a); repeat (10) @(negedge clk); rd(1, b);
    chk(a == b, "R12 holds until new arm", b, a);
    wr(0, 0); wr(1, 7); rd(1, v);
    chk(v == 7, "R9 write while disabled", v, 7);

    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule